// File: doc/BRIEF.md
# Instruction Memory Fill Port

This block gives a host on a narrow register bus a way to load a two-bank instruction memory and to read it back. A host loads a starting word address into the pointer register. Every word it then writes to the data window goes to the memory at the pointer, and the pointer then moves on by one. The lowest pointer bit chooses the bank. Even pointers land in the even bank and odd pointers in the odd bank, so a linear load fills the two banks in turn.

Reads through the data window are allowed only while a readback-enable flag in the control register is set. When the flag is clear, such reads return zero and leave the memory untouched. The memory arrays and the processor fetch path are outside this block.

The bus handshake is simple. A request lasts one cycle, and the acknowledge follows exactly one cycle later. Read data is valid while the acknowledge is high, which covers the one-cycle latency of a synchronous memory read.

Top module: `imem_fill_port`

## Requirements
- R1: After synchronous reset, the pointer is 0, the readback flag is clear, bus_ack is low and no memory enable is asserted.
- R2: Writing register select 0 (the pointer) loads bus_wdata[23:2] into the 22-bit pointer. A read of select 0 returns the pointer in bits [23:2] and zeros in all other bits.
- R3: In the request cycle of a write to select 1 (the data window), mem_addr is pointer[21:1] and mem_wdata is bus_wdata. Exactly one bank write enable is high for that single cycle: mem_even_we when pointer[0] is 0, and mem_odd_we when it is 1.
- R4: Each data-window write increments the 22-bit pointer by one, and the pointer wraps from 0x3FFFFF to 0.
- R5: A read of any register leaves the pointer unchanged.
- R6: When the readback flag is set, a read of select 1 raises the read enable of the bank chosen by pointer[0] in the request cycle. The acknowledge cycle then returns the word from mem_rdata.
- R7: When the readback flag is clear, a read of select 1 asserts no bank read enable and returns 0.
- R8: bus_ack goes high for exactly one cycle, one cycle after every request, and never at any other time. bus_rdata is 0 whenever bus_ack is low.
- R9: Writing select 2 (control) sets the readback flag from bus_wdata[29]. A read of select 2 returns the flag in bit 29 and zeros in all other bits.
- R10: Select 3 is unused. Writes to it change no state, and reads of it return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | One-cycle access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_sel | input | 2 | Register select: 0 pointer, 1 data window, 2 control, 3 unused |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Acknowledge, one cycle after the request |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| mem_addr | output | 21 | Bank word address (pointer without its bank bit) |
| mem_wdata | output | 32 | Word written to the memory |
| mem_even_we | output | 1 | Even bank write enable |
| mem_odd_we | output | 1 | Odd bank write enable |
| mem_even_re | output | 1 | Even bank read enable |
| mem_odd_re | output | 1 | Odd bank read enable |
| mem_rdata | input | 32 | Synchronous read data from the selected bank |

## Verification
The assertions check the following on every cycle:
- each data-window write raises exactly one write enable, in the bank set by the pointer's low bit;
- the pointer steps by one on a fill and holds on every read;
- the acknowledge follows each request by one cycle;
- with readback off, no read enable appears and the returned data is zero.

Only the bench scenarios can show the rest:
- that the correct words land at the correct bank addresses;
- that readback returns what was written;
- that the pointer wraps and that reserved data bits are masked;
- that the unused select leaves state untouched.

// File: rtl/imem_fill_pkg.sv
package imem_fill_pkg;

    localparam int DATA_W   = 32;
    localparam int WORD_AW  = 22;
    localparam int ADDR_LSB = 2;
    localparam int RB_BIT   = 29;

    typedef enum logic [1:0] {
        SEL_PTR  = 2'd0,
        SEL_DATA = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        RSP_ZERO = 2'd0,
        RSP_HOLD = 2'd1,
        RSP_MEM  = 2'd2
    } rsp_kind_e;

    typedef struct packed {
        logic fill_wr;
        logic fill_rd;
        logic ptr_wr;
        logic ctrl_wr;
    } bus_cmd_t;

    function automatic logic [DATA_W-1:0] place_ptr(input logic [WORD_AW-1:0] p);
        logic [DATA_W-1:0] w;
        w = '0;
        w[ADDR_LSB +: WORD_AW] = p;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] place_flag(input logic f);
        logic [DATA_W-1:0] w;
        w = '0;
        w[RB_BIT] = f;
        return w;
    endfunction

endpackage

// File: rtl/imem_fill_ptr.sv
module imem_fill_ptr
    import imem_fill_pkg::*;
#(
    parameter int AW = WORD_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    output logic [AW-1:0] ptr
);

    always_ff @(posedge clk) begin
        if (rst)       ptr <= '0;
        else if (load) ptr <= load_val;
        else if (step) ptr <= ptr + 1'b1;
    end

    // R4: a fill moves the pointer on by one, wrapping at the top
    assert_ptr_step_R4: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (ptr == AW'($past(ptr) + 1'b1)));

    // R5: with no load and no fill the pointer holds
    assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!step && !load) |=> $stable(ptr));

endmodule

// File: rtl/imem_fill_decode.sv
module imem_fill_decode
    import imem_fill_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      req,
    input  logic      wr,
    input  reg_sel_e  sel,
    input  logic      bank_odd,
    input  logic      rb_en,
    output bus_cmd_t  cmd,
    output rsp_kind_e kind,
    output logic      even_we,
    output logic      odd_we,
    output logic      even_re,
    output logic      odd_re
);

    always_comb begin
        cmd  = '0;
        kind = RSP_ZERO;
        if (req) begin
            unique case (sel)
                SEL_PTR: begin
                    cmd.ptr_wr = wr;
                    kind       = wr ? RSP_ZERO : RSP_HOLD;
                end
                SEL_DATA: begin
                    cmd.fill_wr = wr;
                    cmd.fill_rd = !wr && rb_en;
                    kind        = (!wr && rb_en) ? RSP_MEM : RSP_ZERO;
                end
                SEL_CTRL: begin
                    cmd.ctrl_wr = wr;
                    kind        = wr ? RSP_ZERO : RSP_HOLD;
                end
                default: kind = RSP_ZERO;
            endcase
        end
    end

    assign even_we = cmd.fill_wr && !bank_odd;
    assign odd_we  = cmd.fill_wr &&  bank_odd;
    assign even_re = cmd.fill_rd && !bank_odd;
    assign odd_re  = cmd.fill_rd &&  bank_odd;

    // R7: readback off means no bank is read
    assert_rb_gate_R7: assert property (@(posedge clk) disable iff (rst)
        (req && !wr && sel == SEL_DATA && !rb_en) |-> !(even_re || odd_re));

    // R3: enables stay mutually exclusive
    assert_en_excl_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({even_we, odd_we, even_re, odd_re}));

endmodule

// File: rtl/imem_fill_resp.sv
module imem_fill_resp
    import imem_fill_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  rsp_kind_e     kind,
    input  logic [DW-1:0] hold_data,
    input  logic [DW-1:0] mem_rdata,
    output logic          ack,
    output logic [DW-1:0] rdata
);

    rsp_kind_e     kind_q;
    logic [DW-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ack    <= 1'b0;
            kind_q <= RSP_ZERO;
            hold_q <= '0;
        end else begin
            ack    <= req;
            kind_q <= req ? kind : RSP_ZERO;
            hold_q <= (req && kind == RSP_HOLD) ? hold_data : '0;
        end
    end

    always_comb begin
        rdata = '0;
        if (ack) begin
            unique case (kind_q)
                RSP_HOLD: rdata = hold_q;
                RSP_MEM:  rdata = mem_rdata;
                default:  rdata = '0;
            endcase
        end
    end

    // R8: every request is acknowledged on the next cycle, and only then
    assert_ack_follow_R8: assert property (@(posedge clk) disable iff (rst)
        req |=> ack);
    assert_ack_only_R8: assert property (@(posedge clk) disable iff (rst)
        !req |=> !ack);

endmodule

// File: rtl/imem_fill_port.sv
module imem_fill_port
    import imem_fill_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = WORD_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_req,
    input  logic          bus_wr,
    input  logic [1:0]    bus_sel,
    input  logic [DW-1:0] bus_wdata,
    output logic          bus_ack,
    output logic [DW-1:0] bus_rdata,
    output logic [AW-2:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_even_we,
    output logic          mem_odd_we,
    output logic          mem_even_re,
    output logic          mem_odd_re,
    input  logic [DW-1:0] mem_rdata
);

    localparam int BANK_AW = AW - 1;

    reg_sel_e      sel;
    bus_cmd_t      cmd;
    rsp_kind_e     kind;
    logic [AW-1:0] ptr;
    logic          rb_en;
    logic [DW-1:0] hold_data;
    logic          unused_wbits;

    assign sel = reg_sel_e'(bus_sel);

    imem_fill_decode u_dec (
        .clk      (clk),
        .rst      (rst),
        .req      (bus_req),
        .wr       (bus_wr),
        .sel      (sel),
        .bank_odd (ptr[0]),
        .rb_en    (rb_en),
        .cmd      (cmd),
        .kind     (kind),
        .even_we  (mem_even_we),
        .odd_we   (mem_odd_we),
        .even_re  (mem_even_re),
        .odd_re   (mem_odd_re)
    );

    imem_fill_ptr #(.AW(AW)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load     (cmd.ptr_wr),
        .load_val (bus_wdata[ADDR_LSB +: AW]),
        .step     (cmd.fill_wr),
        .ptr      (ptr)
    );

    always_ff @(posedge clk) begin
        if (rst)              rb_en <= 1'b0;
        else if (cmd.ctrl_wr) rb_en <= bus_wdata[RB_BIT];
    end

    assign hold_data = (sel == SEL_PTR) ? place_ptr(ptr) : place_flag(rb_en);

    imem_fill_resp #(.DW(DW)) u_rsp (
        .clk       (clk),
        .rst       (rst),
        .req       (bus_req),
        .kind      (kind),
        .hold_data (hold_data),
        .mem_rdata (mem_rdata),
        .ack       (bus_ack),
        .rdata     (bus_rdata)
    );

    assign mem_addr  = ptr[AW-1 -: BANK_AW];
    assign mem_wdata = bus_wdata;

    assign unused_wbits = ^{bus_wdata[DW-1:RB_BIT+1], bus_wdata[RB_BIT-1:ADDR_LSB+AW],
                            bus_wdata[ADDR_LSB-1:0]};

    // R3: an even pointer fill hits the even bank, an odd one the odd bank
    assert_bank_even_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_wr && sel == SEL_DATA && !ptr[0]) |-> (mem_even_we && !mem_odd_we));
    assert_bank_odd_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_wr && sel == SEL_DATA && ptr[0]) |-> (mem_odd_we && !mem_even_we));

    // R7: gated readback returns zero
    assert_rb_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_wr && sel == SEL_DATA && !rb_en) |=> (bus_rdata == '0));

    // R8: no data without acknowledge
    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !bus_ack |-> (bus_rdata == '0));

endmodule

// File: tb/imem_fill_port_test.sv
module imem_fill_port_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_sel = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ack;
    logic [31:0] bus_rdata;
    logic [20:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_even_we, mem_odd_we, mem_even_re, mem_odd_re;
    logic [31:0] mem_rdata;

    always #4 clk = ~clk;

    imem_fill_port uut (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_even_we(mem_even_we),
        .mem_odd_we(mem_odd_we), .mem_even_re(mem_even_re), .mem_odd_re(mem_odd_re),
        .mem_rdata(mem_rdata)
    );

    // two-bank synchronous memory model
    logic [31:0] ev_mem [64];
    logic [31:0] od_mem [64];
    logic [31:0] rd_q = '0;
    always @(posedge clk) begin
        if (mem_even_we) ev_mem[mem_addr[5:0]] <= mem_wdata;
        if (mem_odd_we)  od_mem[mem_addr[5:0]] <= mem_wdata;
        if (mem_even_re) rd_q <= ev_mem[mem_addr[5:0]];
        if (mem_odd_re)  rd_q <= od_mem[mem_addr[5:0]];
    end
    assign mem_rdata = rd_q;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [21:0] m_ptr = '0;
    bit          m_rb = 0;
    logic [31:0] written [logic [21:0]];

    logic [31:0] exp_q [$];
    string       tag_q [$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every acknowledge
    always @(negedge clk) begin
        if (!rst && bus_ack) begin
            if (exp_q.size() == 0) begin
                chk(0, "R8 acknowledge without request", 32'd1, 32'd0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(bus_rdata === e, t, bus_rdata, e);
            end
        end
    end

    task automatic bus_op(input bit wr, input logic [1:0] sel, input logic [31:0] d,
                          input logic [31:0] exp, input string tag);
        bit fw, fr;
        @(negedge clk);
        bus_req = 1'b1; bus_wr = wr; bus_sel = sel; bus_wdata = d;
        exp_q.push_back(wr ? 32'd0 : exp);
        tag_q.push_back(tag);
        #1;
        fw = wr && sel == 2'd1;
        fr = !wr && sel == 2'd1 && m_rb;
        chk(bus_ack === 1'b0, "R8 no ack in request cycle", {31'd0, bus_ack}, 32'd0);
        chk(mem_even_we === (fw && !m_ptr[0]) && mem_odd_we === (fw && m_ptr[0]),
            "R3 bank write enables", {30'd0, mem_odd_we, mem_even_we},
            {30'd0, fw && m_ptr[0], fw && !m_ptr[0]});
        chk(mem_even_re === (fr && !m_ptr[0]) && mem_odd_re === (fr && m_ptr[0]),
            "R6 R7 bank read enables", {30'd0, mem_odd_re, mem_even_re},
            {30'd0, fr && m_ptr[0], fr && !m_ptr[0]});
        if (fw || fr)
            chk(mem_addr === m_ptr[21:1], "R3 bank address", {11'd0, mem_addr}, {11'd0, m_ptr[21:1]});
        if (fw)
            chk(mem_wdata === d, "R3 write data", mem_wdata, d);
        @(negedge clk);
        bus_req = 1'b0;
        if (wr && sel == 2'd0) m_ptr = d[23:2];
        if (fw) begin
            written[m_ptr] = d;
            m_ptr = m_ptr + 22'd1;
        end
        if (wr && sel == 2'd2) m_rb = d[29];
    endtask

    function automatic logic [31:0] fill_exp();
        if (m_rb && written.exists(m_ptr)) return written[m_ptr];
        return 32'd0;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            chk(0, "watchdog", 32'd0, 32'd1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(bus_ack === 1'b0 && bus_rdata === 32'd0, "R1 ack idle in reset", {31'd0, bus_ack}, 32'd0);
        chk({mem_even_we, mem_odd_we, mem_even_re, mem_odd_re} === 4'd0, "R1 enables idle",
            {28'd0, mem_even_we, mem_odd_we, mem_even_re, mem_odd_re}, 32'd0);
        rst = 1'b0;

        bus_op(0, 2'd0, 0, 32'h0, "R1 pointer zero after reset");
        bus_op(0, 2'd2, 0, 32'h0, "R1 readback flag clear after reset");

        bus_op(1, 2'd0, 32'hFF00_0013, 0, "R2 pointer write");
        bus_op(0, 2'd0, 0, 32'h0000_0010, "R2 masked pointer read");

        for (int i = 0; i < 4; i++)
            bus_op(1, 2'd1, 32'hA5A5_0000 + i, 0, "R3 fill write");
        bus_op(0, 2'd0, 0, 32'h0000_0020, "R4 pointer advanced by four");

        bus_op(0, 2'd1, 0, 32'h0, "R7 gated readback returns zero");
        bus_op(0, 2'd0, 0, 32'h0000_0020, "R5 read leaves pointer");

        bus_op(1, 2'd2, 32'hFFFF_FFFF, 0, "R9 control write");
        bus_op(0, 2'd2, 0, 32'h2000_0000, "R9 control read");

        bus_op(1, 2'd0, 32'h0000_0010, 0, "R2 pointer to 4");
        bus_op(0, 2'd1, 0, fill_exp(), "R6 even bank readback");
        bus_op(0, 2'd1, 0, fill_exp(), "R5 repeated readback same word");
        bus_op(1, 2'd0, 32'h0000_0014, 0, "R2 pointer to 5");
        bus_op(0, 2'd1, 0, fill_exp(), "R6 odd bank readback");

        bus_op(1, 2'd3, 32'h0000_003C, 0, "R10 unused write");
        bus_op(0, 2'd3, 0, 32'h0, "R10 unused read zero");
        bus_op(0, 2'd0, 0, 32'h0000_0014, "R10 pointer untouched");
        bus_op(0, 2'd2, 0, 32'h2000_0000, "R10 flag untouched");

        bus_op(1, 2'd0, 32'h00FF_FFFC, 0, "R2 pointer to top");
        bus_op(1, 2'd1, 32'hDEAD_BEEF, 0, "R4 fill at top word");
        bus_op(0, 2'd0, 0, 32'h0, "R4 pointer wrapped to zero");
        bus_op(1, 2'd0, 32'h00FF_FFFC, 0, "R2 pointer to top again");
        bus_op(0, 2'd1, 0, fill_exp(), "R6 readback of top word");

        bus_op(1, 2'd2, 32'h0, 0, "R9 clear flag");
        bus_op(0, 2'd1, 0, 32'h0, "R7 readback gated again");

        @(negedge clk);
        @(negedge clk);
        chk(exp_q.size() == 0, "R8 every request acknowledged", exp_q.size(), 32'd0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule